// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus in front of a 2048-byte
on-chip store. A system clock oversamples the bus clock and data lines. The
block detects start, repeated start and stop conditions and shifts bytes in.
It answers only when a select byte carries the fixed device code and the
settings on three chip-enable inputs. The data line is open-drain. The block
only ever pulls it low, through a single drive-low output, and the pull-up
lives outside.

After a write select, two address bytes set an 11-bit pointer. Any data bytes
that follow are stored in that 16-byte page, wrapping within it. After a read
select, bytes are sent from the pointer and the pointer advances through the
whole store for as long as the bus master acknowledges. A write-lock input
lets select and address bytes through but refuses data bytes. A power-on
hold input keeps the block silent and idle.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A select byte, sent MSB first, is acknowledged when bits 7..4 equal 4'b1010 and bits 3..1 equal chip_en[2:0]. Bit 0 selects read (1) or write (0).
- R2: A select byte with a wrong device code or wrong chip-enable bits gets no acknowledge. Every later byte is ignored until the next start condition.
- R3: Each accepted byte is acknowledged by holding the data line low for the whole ninth clock.
- R4: After a write select, the pointer is loaded from two address bytes. The high byte comes first and its low 3 bits are address bits 10..8. Its upper 5 bits are ignored. The low byte is address bits 7..0. A random read (address write, repeated start, read select) returns the byte at that address.
- R5: Successive data bytes in one write transfer go to consecutive addresses. The low 4 address bits wrap within the 16-byte page, and the upper 7 bits never change.
- R6: A read select with no address phase (current-address read) returns the byte after the last one read or written.
- R7: A read continues while the master acknowledges each byte. The pointer wraps from 2047 to 0. After a master non-acknowledge the data line is released for good until the next start.
- R8: While wr_lock is high, select and address bytes are still acknowledged. Data bytes get no acknowledge and leave the store unchanged.
- R9: While por_active is high the block never pulls the data line low, and it ignores every select byte.
- R10: The drive-low output changes only after a falling bus-clock edge, or on a start, stop or power-on hold. It never changes while the bus clock is high.
- R11: After reset the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_active | input | 1 | Power-on hold. High keeps the block idle and silent |
| chip_en | input | 3 | Expected values of select bits 3..1 |
| wr_lock | input | 1 | High refuses data bytes of write transfers |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_drive_low | output | 1 | High pulls the open-drain data line low |

## Verification
The select byte is swept over all 64 pairs of chip-enable setting and select bits 3..1, plus every wrong device code. This separates exact matching from partial matching. It also shows whether a rejected target stays silent through a following byte.

Writes to scattered addresses, each sent with different junk in the top address bits, followed by random reads, show whether the pointer is loaded from the correct bits. A page write that starts at offset 3 and a 15-byte read of the same page tell in-page wrap apart from a plain increment. Writes and reads that run across the top of the store test the full-range wrap.

Locked writes, power-on hold and the behaviour after a master non-acknowledge are each checked at the bus lines.

// File: rtl/ee_pkg.sv
package ee_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_SEL  = 3'd1,
      PH_AHI  = 3'd2,
      PH_ALO  = 3'd3,
      PH_WR   = 3'd4,
      PH_RD   = 3'd5
   } phase_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/ee_line_sense.sv
module ee_line_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   logic scl_s, sda_s, scl_p, sda_p;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_s <= 1'b1;
            sda_s <= 1'b1;
         end else begin
            scl_s <= scl_i;
            sda_s <= sda_i;
         end
      end
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
         end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
         end
      end
      assign scl_s = scl_q[SYNC_STAGES-1];
      assign sda_s = sda_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/ee_ptr.sv
module ee_ptr #(
   parameter int AW = 11,
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc_page,
   input  logic          inc_full,
   output logic [AW-1:0] ptr
);

   logic [AW-1:0] page_next;

   if (PW >= AW) begin : g_flat
      assign page_next = ptr + 1'b1;
   end else begin : g_split
      logic [PW-1:0] low_next;
      assign low_next  = ptr[PW-1:0] + 1'b1;
      assign page_next = {ptr[AW-1:PW], low_next};

      // R5: a page increment never touches the page number
      a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
         $past(inc_page && !load && !clr) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (inc_page) begin
         ptr <= page_next;
      end else if (inc_full) begin
         ptr <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/ee_mem.sv
module ee_mem #(
   parameter int DEPTH = 2048,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
   parameter int         MEM_BYTES   = 2048,
   parameter int         PAGE_BYTES  = 16,
   parameter logic [3:0] DEV_CODE    = 4'b1010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_active,
   input  logic [2:0] chip_en,
   input  logic       wr_lock,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_drive_low
);

   import ee_pkg::*;

   localparam int AW   = $clog2(MEM_BYTES);
   localparam int PW   = $clog2(PAGE_BYTES);
   localparam int HI_W = AW - BYTE_W;

   if (MEM_BYTES != (1 << AW)) begin : g_bad_depth
      $error("MEM_BYTES must be a power of two");
   end
   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("address must span two bytes");
   end
   if (PAGE_BYTES != (1 << PW) || PAGE_BYTES < 2 || PAGE_BYTES > MEM_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two within the store");
   end

   logic          sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   phase_t        phase;
   logic [3:0]    bitcnt;
   logic          in_ack, drv, rw_rd, mack;
   logic [7:0]    shreg, txreg, mem_rd;
   logic [HI_W-1:0] addr_hi;
   logic [AW-1:0] ptr;
   logic          byte_done, ack_end, sel_ok, rd_advance, ptr_load, mem_we;

   ee_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   assign byte_done  = scl_fall && (bitcnt == 4'd8) && !in_ack && (phase != PH_IDLE);
   assign ack_end    = scl_fall && in_ack;
   assign sel_ok     = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == chip_en);
   assign rd_advance = ack_end && !por_active && !start_evt && !stop_evt &&
                       (((phase == PH_SEL) && rw_rd) || ((phase == PH_RD) && mack));
   assign ptr_load   = byte_done && !por_active && (phase == PH_ALO);
   assign mem_we     = byte_done && !por_active && (phase == PH_WR) && !wr_lock;

   ee_ptr #(.AW(AW), .PW(PW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (por_active),
      .load     (ptr_load),
      .load_val ({addr_hi, shreg}),
      .inc_page (mem_we),
      .inc_full (rd_advance),
      .ptr      (ptr)
   );

   ee_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (ptr),
      .wdata (shreg),
      .raddr (ptr),
      .rdata (mem_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         in_ack  <= 1'b0;
         drv     <= 1'b0;
         rw_rd   <= 1'b0;
         mack    <= 1'b0;
         shreg   <= '0;
         txreg   <= '0;
         addr_hi <= '0;
      end else if (por_active) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         in_ack  <= 1'b0;
         drv     <= 1'b0;
         rw_rd   <= 1'b0;
         mack    <= 1'b0;
      end else if (start_evt) begin
         phase  <= PH_SEL;
         bitcnt <= '0;
         in_ack <= 1'b0;
         drv    <= 1'b0;
      end else if (stop_evt) begin
         phase  <= PH_IDLE;
         in_ack <= 1'b0;
         drv    <= 1'b0;
      end else begin
         if (scl_rise) begin
            if (phase == PH_RD && in_ack) begin
               mack <= ~sda_lvl;
            end else if (phase != PH_IDLE && bitcnt < 4'd8) begin
               shreg  <= {shreg[6:0], sda_lvl};
               bitcnt <= bitcnt + 4'd1;
            end
         end
         if (byte_done) begin
            in_ack <= 1'b1;
            case (phase)
               PH_SEL: begin
                  if (sel_ok) begin
                     drv   <= 1'b1;
                     rw_rd <= shreg[0];
                  end else begin
                     phase  <= PH_IDLE;
                     in_ack <= 1'b0;
                     drv    <= 1'b0;
                  end
               end
               PH_AHI: begin
                  drv     <= 1'b1;
                  addr_hi <= shreg[HI_W-1:0];
               end
               PH_ALO:  drv <= 1'b1;
               PH_WR:   drv <= ~wr_lock;
               default: drv <= 1'b0;
            endcase
         end else if (ack_end) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            drv    <= 1'b0;
            case (phase)
               PH_SEL: begin
                  if (rw_rd) begin
                     phase <= PH_RD;
                     txreg <= mem_rd;
                     drv   <= ~mem_rd[7];
                  end else begin
                     phase <= PH_AHI;
                  end
               end
               PH_AHI: phase <= PH_ALO;
               PH_ALO: phase <= PH_WR;
               PH_RD: begin
                  if (mack) begin
                     txreg <= mem_rd;
                     drv   <= ~mem_rd[7];
                  end else begin
                     phase <= PH_IDLE;
                  end
               end
               default: phase <= phase;
            endcase
         end else if (scl_fall && phase == PH_RD && bitcnt != 4'd0 && bitcnt < 4'd8) begin
            drv   <= ~txreg[6];
            txreg <= {txreg[6:0], 1'b0};
         end
      end
   end

   assign sda_drive_low = drv;

   // R10: drive is taken only after a falling bus-clock edge
   a_r10_take_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> $past(scl_fall));

   // R10: drive is dropped only on a falling edge or a bus/power event
   a_r10_drop_on_event: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_drive_low) |-> $past(scl_fall || start_evt || stop_evt || por_active));

   // R9: power-on hold keeps the line released
   a_r9_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
      por_active |=> !sda_drive_low);

   // R8: a data-phase acknowledge needs the lock low at the decision edge
   a_r8_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) && phase == PH_WR |-> !$past(wr_lock));

endmodule

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;

   localparam int CLK_PERIOD = 10;
   localparam int MEM        = 2048;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por = 1'b0;
   logic       lock = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [2:0] ce = 3'd5;
   logic       drv;
   wire        sda_line = m_sda & ~drv;

   int vecs = 0;
   int fails = 0;
   int r10_bad = 0;
   logic [7:0] model [MEM];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_eeprom_slave u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .por_active    (por),
      .chip_en       (ce),
      .wr_lock       (lock),
      .scl_i         (m_scl),
      .sda_i         (sda_line),
      .sda_drive_low (drv)
   );

   // R10 monitor: drive must hold while the bus clock stays high
   logic scl_d = 1'b1;
   logic drv_d = 1'b0;
   always @(posedge clk) begin
      if (rst_n && m_scl && scl_d && (drv !== drv_d)) r10_bad++;
      scl_d = m_scl;
      drv_d = drv;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vecs++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic clock_bit(input logic v, output logic s);
      m_sda = v;
      tick(5);
      m_scl = 1'b1;
      tick(6);
      s = sda_line;
      tick(5);
      m_scl = 1'b0;
      tick(2);
   endtask

   task automatic start_c();
      m_sda = 1'b1;
      tick(3);
      m_scl = 1'b1;
      tick(6);
      m_sda = 1'b0;
      tick(6);
      m_scl = 1'b0;
      tick(2);
   endtask

   task automatic stop_c();
      m_sda = 1'b0;
      tick(3);
      m_scl = 1'b1;
      tick(6);
      m_sda = 1'b1;
      tick(8);
   endtask

   task automatic tx(input logic [7:0] b, output logic ak);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
      clock_bit(1'b1, s);
      ak = ~s;
   endtask

   task automatic rx(input logic master_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         b[i] = s;
      end
      clock_bit(~master_ack, s);
   endtask

   task automatic set_addr(input logic [10:0] a, input logic [4:0] junk);
      logic ak;
      start_c();
      tx({4'hA, ce, 1'b0}, ak);
      chk("R1 write select acked", ak, 1);
      tx({junk, a[10:8]}, ak);
      chk("R4 address high acked", ak, 1);
      tx(a[7:0], ak);
      chk("R4 address low acked", ak, 1);
   endtask

   task automatic write_one(input logic [10:0] a, input logic [7:0] d, input logic [4:0] junk);
      logic ak;
      set_addr(a, junk);
      tx(d, ak);
      chk("R3 data byte acked", ak, 1);
      stop_c();
      model[a] = d;
   endtask

   task automatic read_start(input logic [10:0] a, input logic [4:0] junk);
      logic ak;
      set_addr(a, junk);
      start_c();
      tx({4'hA, ce, 1'b1}, ak);
      chk("R1 read select acked", ak, 1);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog over all requirements: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic       ak;
      logic       s;
      logic [7:0] b;
      logic [10:0] a;
      int         held;

      tick(4);
      rst_n = 1'b1;
      tick(4);
      chk("R11 line released after reset", drv, 0);

      // R1 / R2: every chip-enable setting against every select pattern
      for (int c = 0; c < 8; c++) begin
         for (int sb = 0; sb < 8; sb++) begin
            ce = c[2:0];
            start_c();
            tx({4'hA, sb[2:0], 1'b0}, ak);
            if (sb == c) chk("R1 matching select acked", ak, 1);
            else         chk("R2 mismatched chip-enable ignored", ak, 0);
            stop_c();
         end
      end

      // R2: wrong device codes, then a following byte stays unanswered
      ce = 3'd5;
      for (int code = 0; code < 16; code++) begin
         if (code != 10) begin
            start_c();
            tx({code[3:0], 3'd5, 1'b0}, ak);
            chk("R2 wrong device code ignored", ak, 0);
            tx(8'h00, ak);
            chk("R2 idle until next start", ak, 0);
            stop_c();
         end
      end

      // R4: scattered byte writes with junk in the top address bits
      for (int i = 0; i < 32; i++) begin
         a = 11'(i * 67 + 3);
         write_one(a, 8'(i * 29 + 7), 5'(i));
      end
      for (int i = 0; i < 32; i++) begin
         a = 11'(i * 67 + 3);
         read_start(a, ~5'(i));
         rx(1'b0, b);
         chk("R4 random read data", b, model[a]);
         stop_c();
      end

      // R5: page write from offset 3 wraps inside its page
      set_addr(11'h2F3, 5'd0);
      for (int j = 0; j < 16; j++) begin
         tx(8'(8'h80 + j), ak);
         chk("R5 page byte acked", ak, 1);
         model[{7'h2F, 4'(j + 3)}] = 8'(8'h80 + j);
      end
      stop_c();

      // R7: sequential read over the page
      read_start(11'h2F0, 5'd0);
      for (int j = 0; j < 15; j++) begin
         rx(j != 14, b);
         chk("R7 sequential read data", b, model[11'(11'h2F0 + j)]);
      end
      stop_c();

      // R6: current-address read continues after the last byte read
      start_c();
      tx({4'hA, ce, 1'b1}, ak);
      chk("R6 current read select acked", ak, 1);
      rx(1'b0, b);
      chk("R6 current address read data", b, model[11'h2FF]);
      stop_c();

      // R7: read across the top of the store
      write_one(11'd2046, 8'h5A, 5'd0);
      write_one(11'd2047, 8'hA5, 5'd0);
      write_one(11'd0, 8'h3C, 5'd0);
      read_start(11'd2046, 5'd3);
      rx(1'b1, b);
      chk("R7 read at 2046", b, model[11'd2046]);
      rx(1'b1, b);
      chk("R7 read at 2047", b, model[11'd2047]);
      rx(1'b0, b);
      chk("R7 wrap to address 0", b, model[11'd0]);
      held = 0;
      for (int k = 0; k < 9; k++) begin
         clock_bit(1'b1, s);
         if (s !== 1'b1) held++;
      end
      chk("R7 line released after master NACK", held, 0);
      stop_c();

      // R8: write lock refuses data but leaves the store as it was
      lock = 1'b1;
      set_addr(11'd3, 5'd0);
      chk("R8 address phase acked while locked", 1, 1);
      tx(8'hEE, ak);
      chk("R8 data refused while locked", ak, 0);
      stop_c();
      lock = 1'b0;
      read_start(11'd3, 5'd0);
      rx(1'b0, b);
      chk("R8 locked byte unchanged", b, model[11'd3]);
      stop_c();

      // R9: power-on hold silences the block
      por = 1'b1;
      tick(4);
      start_c();
      tx({4'hA, ce, 1'b0}, ak);
      chk("R9 select ignored during hold", ak, 0);
      chk("R9 line released during hold", drv, 0);
      stop_c();
      por = 1'b0;
      tick(4);
      start_c();
      tx({4'hA, ce, 1'b0}, ak);
      chk("R9 select acked after hold", ak, 1);
      stop_c();

      chk("R10 no drive change while clock high", r10_bad, 0);

      summary();
      $finish;
   end

endmodule